// File: doc/BRIEF.md
# Oversampled Parity Serial Port

This block is a full-duplex asynchronous serial port for a host link. It runs from a fixed crystal reference and picks one of two bit rates from a static select input. With a 4.9152 MHz reference and the default settings it runs at 9600 or 19200 baud, with 32 samples per bit. A build-time option halves the internal divide so the block can run from a 2.4576 MHz reference instead.

Each character on the line is one low start bit, eight data bits with the least significant bit first, one even parity bit, and one high stop bit. The receiver oversamples the line and takes a three-sample majority vote near the middle of each bit. It rejects start glitches and hands up every byte with separate parity and framing flags. The transmitter takes bytes over a valid/ready handshake. It holds one waiting byte so that characters leave with no idle time between them. A polarity input inverts both pins, so the line can idle low instead of high.

Receiver states:
- `RX_IDLE`: waits for a falling edge between two sample ticks.
- `RX_START`: goes back to idle if the vote at mid-bit reads high (glitch). Otherwise it moves to `RX_DATA` at the end of the bit.
- `RX_DATA`: moves to `RX_PARITY` after the eighth bit.
- `RX_PARITY`: moves to `RX_STOP`.
- `RX_STOP`: reports the byte at the mid-bit vote and returns to `RX_IDLE`.

Transmitter states:
- `TX_IDLE`: moves to `TX_START` on an accepted byte.
- `TX_START`, `TX_DATA` and `TX_PARITY`: each advances after its bit or bits, in that order, ending in `TX_STOP`.
- `TX_STOP`: moves to `TX_START` when a byte is waiting or is accepted in the stop bit's last cycle. Otherwise it moves to `TX_IDLE`.

Top module: `serial_parity_port`

## Requirements
- R1: With `idle_low`=0, `tx_pin` sends a 0 start bit, then the eight data bits least significant first, then the parity bit, then a 1 stop bit, and idles at 1.
- R2: The transmitted parity bit equals the XOR of the eight data bits, so the nine bits together hold an even number of ones.
- R3: One bit lasts 32×`REF_PER_SAMPLE_FAST` reference cycles when `rate_slow`=0 (256 by default, 19200 baud) and twice that when `rate_slow`=1 (512, 9600 baud). Setting `HALF_REF`=1 halves both counts.
- R4: A well-formed received frame produces exactly one single-cycle `rx_valid` pulse, with the byte on `rx_data` and both error flags at 0.
- R5: When the received parity bit differs from the XOR of the received data bits, `rx_parity_err` is 1 in the `rx_valid` cycle. Neither flag is ever 1 outside an `rx_valid` cycle.
- R6: A stop bit that votes 0 sets `rx_frame_err` in the `rx_valid` cycle, and the received byte is still delivered.
- R7: A low pulse on the line shorter than half a bit is treated as a glitch and produces no `rx_valid`.
- R8: Each received bit is the majority of samples 15, 16 and 17 of its 32, so one wrong sample among them does not change the bit.
- R9: With `idle_low`=1, `tx_pin` is the complement of the R1 waveform (idle 0) and `rx_pin` is read inverted.
- R10: `tx_ready` goes to 0 in the cycle after a byte is accepted from idle and returns to 1 when that byte's stop bit begins.
- R11: A byte accepted during a stop bit starts its start bit right as that stop bit ends. Successive start edges are 11 bit times apart, and the first frame after idle may be up to one sample period shorter.
- R12: After a framing error the receiver starts no new frame until the line has returned to idle and fallen again. The next frame after that is received correctly.
- R13: After reset, `tx_pin` is at the idle level, `tx_ready` is 1 and `rx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| rate_slow | input | 1 | 1 selects the slower rate, 0 the faster one |
| idle_low | input | 1 | 1 makes both line pins idle low |
| rx_pin | input | 1 | Serial input from the line |
| tx_pin | output | 1 | Serial output to the line |
| tx_data | input | DATA_W | Byte offered for sending |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Byte is taken on a clock edge where valid and ready are both 1 |
| rx_data | output | DATA_W | Last received byte |
| rx_valid | output | 1 | Single-cycle pulse: a byte is complete |
| rx_parity_err | output | 1 | Parity mismatch on this byte |
| rx_frame_err | output | 1 | Stop bit read as 0 on this byte |

## Verification
The in-RTL assertions check every cycle the following:
- the sample tick never fires twice in a row;
- `rx_valid` lasts exactly one cycle;
- the error flags appear only together with `rx_valid`;
- `tx_ready` drops after a load from idle;
- the transmit line moves only on a sample tick or a load.

Other behaviour needs the bench's scenarios with a reference model:
- bit order and parity values;
- the bit period at each rate;
- majority voting against a single bad sample;
- glitch rejection;
- resynchronisation after a framing error;
- the gap-free spacing of queued characters;
- the inverted polarity.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;
    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP
    } rx_state_e;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PARITY, TX_STOP
    } tx_state_e;
endpackage

// File: rtl/sample_tick_gen.sv
module sample_tick_gen #(
    parameter int REF_PER_SAMPLE_FAST = 8,
    parameter bit HALF_REF            = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rate_slow,
    output logic tick
);
    localparam int FAST_DIV = HALF_REF ? REF_PER_SAMPLE_FAST / 2 : REF_PER_SAMPLE_FAST;
    localparam int SLOW_DIV = 2 * FAST_DIV;
    localparam int CW       = $clog2(SLOW_DIV);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    // one tick per sample period; the rate select only changes the terminal count
    assign limit = rate_slow ? CW'(SLOW_DIV - 1) : CW'(FAST_DIV - 1);
    assign tick  = (cnt >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= tick ? '0 : cnt + 1'b1;
    end

    // R3: sample ticks are spaced by at least two reference cycles
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/serial_rx.sv
module serial_rx
    import serial_port_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SPB    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line_raw,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_parity_err,
    output logic              rx_frame_err
);
    localparam int CW  = $clog2(SPB);
    localparam int IW  = $clog2(DATA_W);
    localparam int MID = SPB / 2;

    rx_state_e         state, state_nx;
    logic [1:0]        sync_q;
    logic              s, prev_s;
    logic [CW-1:0]     cnt;
    logic [IW-1:0]     idx;
    logic [DATA_W-1:0] shreg;
    logic              par_q;
    logic [1:0]        ones;
    logic              bit_done, decide, vote, fall;

    assign s        = sync_q[1];
    assign fall     = tick && prev_s && !s;
    assign bit_done = tick && (cnt == CW'(SPB - 1));
    assign decide   = tick && (cnt == CW'(MID + 1));
    assign vote     = ({1'b0, ones} + {2'b00, s}) >= 3'd2;

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:   if (fall) state_nx = RX_START;
            RX_START:  if (decide && vote) state_nx = RX_IDLE;
                       else if (bit_done) state_nx = RX_DATA;
            RX_DATA:   if (bit_done && idx == IW'(DATA_W - 1)) state_nx = RX_PARITY;
            RX_PARITY: if (bit_done) state_nx = RX_STOP;
            RX_STOP:   if (decide) state_nx = RX_IDLE;
            default:   state_nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q        <= 2'b11;
            prev_s        <= 1'b1;
            cnt           <= '0;
            idx           <= '0;
            shreg         <= '0;
            par_q         <= 1'b0;
            ones          <= '0;
            rx_data       <= '0;
            rx_valid      <= 1'b0;
            rx_parity_err <= 1'b0;
            rx_frame_err  <= 1'b0;
        end else begin
            sync_q        <= {sync_q[0], line_raw};
            rx_valid      <= 1'b0;
            rx_parity_err <= 1'b0;
            rx_frame_err  <= 1'b0;
            if (tick) prev_s <= s;
            if (state == RX_IDLE) begin
                cnt  <= CW'(1);       // the edge sample is index 0
                idx  <= '0;
                ones <= '0;
            end else if (tick) begin
                cnt <= bit_done ? '0 : cnt + 1'b1;
                if (cnt == CW'(MID - 1) || cnt == CW'(MID)) ones <= ones + {1'b0, s};
                if (decide) begin
                    ones <= '0;
                    unique case (state)
                        RX_DATA:   shreg <= {vote, shreg[DATA_W-1:1]};
                        RX_PARITY: par_q <= vote;
                        RX_STOP: begin
                            rx_valid      <= 1'b1;
                            rx_data       <= shreg;
                            rx_parity_err <= (^shreg) ^ par_q;
                            rx_frame_err  <= !vote;
                        end
                        default: ;
                    endcase
                end
                if (bit_done && state == RX_DATA) idx <= idx + 1'b1;
            end
        end
    end

    // R4: a received byte is reported in exactly one cycle
    a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R5: error flags only accompany a delivered byte
    a_r5_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_parity_err || rx_frame_err) |-> rx_valid);
endmodule

// File: rtl/serial_tx.sv
module serial_tx
    import serial_port_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SPB    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              tx_line
);
    localparam int CW = $clog2(SPB);
    localparam int IW = $clog2(DATA_W);

    tx_state_e         state, state_nx;
    logic [CW-1:0]     cnt;
    logic [IW-1:0]     idx;
    logic [DATA_W-1:0] shreg, nxt_q;
    logic              par_q, pend;
    logic              bit_done, accept;

    assign bit_done = tick && (cnt == CW'(SPB - 1));
    assign accept   = tx_valid && tx_ready;

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE:   if (accept) state_nx = TX_START;
            TX_START:  if (bit_done) state_nx = TX_DATA;
            TX_DATA:   if (bit_done && idx == IW'(DATA_W - 1)) state_nx = TX_PARITY;
            TX_PARITY: if (bit_done) state_nx = TX_STOP;
            TX_STOP:   if (bit_done) state_nx = (pend || accept) ? TX_START : TX_IDLE;
            default:   state_nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        tx_ready = 1'b0;
        tx_line  = 1'b1;
        unique case (state)
            TX_IDLE:   tx_ready = 1'b1;
            TX_START:  tx_line  = 1'b0;
            TX_DATA:   tx_line  = shreg[0];
            TX_PARITY: tx_line  = par_q;
            TX_STOP:   tx_ready = !pend;
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            nxt_q <= '0;
            par_q <= 1'b0;
            pend  <= 1'b0;
        end else if (state == TX_IDLE) begin
            cnt <= '0;
            idx <= '0;
            if (accept) begin
                shreg <= tx_data;
                par_q <= ^tx_data;
            end
        end else begin
            if (tick) cnt <= bit_done ? '0 : cnt + 1'b1;
            if (state == TX_DATA && bit_done) begin
                shreg <= shreg >> 1;
                idx   <= idx + 1'b1;
            end
            if (state == TX_STOP) begin
                if (bit_done) begin
                    idx  <= '0;
                    pend <= 1'b0;
                    if (pend) begin
                        shreg <= nxt_q;
                        par_q <= ^nxt_q;
                    end else if (accept) begin
                        shreg <= tx_data;
                        par_q <= ^tx_data;
                    end
                end else if (accept) begin
                    nxt_q <= tx_data;
                    pend  <= 1'b1;
                end
            end
        end
    end

    // R10: a byte loaded from idle removes ready on the next cycle
    a_r10_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE && accept) |=> !tx_ready);
    // R1: within a frame the line only moves after a sample tick
    a_r1_line_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (state != TX_IDLE && $past(state) != TX_IDLE && !$past(tick)) |-> $stable(tx_line));
endmodule

// File: rtl/serial_parity_port.sv
module serial_parity_port #(
    parameter int DATA_W              = 8,
    parameter int SAMPLES_PER_BIT     = 32,
    parameter int REF_PER_SAMPLE_FAST = 8,
    parameter bit HALF_REF            = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_slow,
    input  logic              idle_low,
    input  logic              rx_pin,
    output logic              tx_pin,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_parity_err,
    output logic              rx_frame_err
);
    logic tick;
    logic tx_line;
    logic rx_line;

    // internal logic always sees an idle-high line
    assign rx_line = rx_pin ^ idle_low;
    assign tx_pin  = tx_line ^ idle_low;

    sample_tick_gen #(
        .REF_PER_SAMPLE_FAST(REF_PER_SAMPLE_FAST),
        .HALF_REF           (HALF_REF)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_slow(rate_slow),
        .tick     (tick)
    );

    serial_rx #(.DATA_W(DATA_W), .SPB(SAMPLES_PER_BIT)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .line_raw     (rx_line),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_parity_err(rx_parity_err),
        .rx_frame_err (rx_frame_err)
    );

    serial_tx #(.DATA_W(DATA_W), .SPB(SAMPLES_PER_BIT)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .tx_data (tx_data),
        .tx_valid(tx_valid),
        .tx_ready(tx_ready),
        .tx_line (tx_line)
    );
endmodule

// File: tb/serial_parity_port_tb.sv
module serial_parity_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rate_slow = 1'b0;
    logic       idle_low = 1'b0;
    logic       rx_pin = 1'b1;
    logic       tx_pin;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] rx_data;
    logic       rx_valid, rx_parity_err, rx_frame_err;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int rx_seen = 0;
    bit done = 0;
    logic [9:0] rx_exp[$];
    logic [7:0] tx_exp[$];
    int tx_starts[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    serial_parity_port u_dut (
        .clk(clk), .rst_n(rst_n), .rate_slow(rate_slow), .idle_low(idle_low),
        .rx_pin(rx_pin), .tx_pin(tx_pin), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err)
    );

    function automatic int bit_len();
        return rate_slow ? 512 : 256;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", checks, fails);
    endtask

    // receive-side reference: every reported byte must match the queue head
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            rx_seen++;
            if (rx_exp.size() == 0) begin
                chk("R7 unexpected rx_valid", 1, 0);
            end else begin
                logic [9:0] e;
                e = rx_exp.pop_front();
                chk(e[9] ? "R6" : (e[8] ? "R5" : "R4"),
                    {rx_frame_err, rx_parity_err, rx_data}, e);
            end
        end
    end

    // transmit-side reference: decode the line at mid-bit
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (tx_pin ^ idle_low) == 1'b0) begin
                int b;
                logic [7:0] d;
                logic p, st;
                b = bit_len();
                tx_starts.push_back(cyc);
                repeat (b / 2 - 1) @(negedge clk);
                chk("R1 start bit", tx_pin ^ idle_low, 0);
                for (int k = 0; k < 8; k++) begin
                    repeat (b) @(negedge clk);
                    d[k] = tx_pin ^ idle_low;
                end
                repeat (b) @(negedge clk);
                p = tx_pin ^ idle_low;
                repeat (b) @(negedge clk);
                st = tx_pin ^ idle_low;
                if (tx_exp.size() == 0) begin
                    chk("R1 unexpected frame", 1, 0);
                end else begin
                    logic [7:0] e;
                    e = tx_exp.pop_front();
                    chk("R1 data", d, e);
                    chk("R2 parity", p, ^e);
                end
                chk("R1 stop bit", st, 1);
            end
        end
    end

    task automatic drive(input logic v, input int n);
        rx_pin = v ^ idle_low;
        repeat (n) @(negedge clk);
    endtask

    task automatic rx_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                            input int spike);
        int b;
        int dv;
        b  = bit_len();
        dv = b / 32;
        rx_exp.push_back({bad_stop, bad_par, d});
        drive(1'b0, b);
        for (int k = 0; k < 8; k++) begin
            if (k == spike) begin
                drive(d[k], 16 * dv);
                drive(!d[k], dv);
                drive(d[k], b - 17 * dv);
            end else begin
                drive(d[k], b);
            end
        end
        drive((^d) ^ bad_par, b);
        drive(!bad_stop, b);
        if (!bad_stop) drive(1'b1, b);
    endtask

    task automatic tx_send(input logic [7:0] d);
        tx_exp.push_back(d);
        tx_data  = d;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic tx_drain();
        while (tx_exp.size() != 0) @(negedge clk);
        repeat (bit_len()) @(negedge clk);
    endtask

    task automatic ready_time(input string req);
        int n;
        int b;
        b = bit_len();
        n = 0;
        while (!tx_ready) begin
            @(negedge clk);
            n++;
        end
        chk(req, (n >= 10 * b - b / 32 + 1) && (n <= 10 * b), 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all) actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 tx idle", tx_pin, 1);
        chk("R13 ready", tx_ready, 1);
        chk("R13 rx_valid", rx_valid, 0);

        // receive: plain frames (R4), parity error (R5)
        rx_frame(8'hA5, 0, 0, -1);
        rx_frame(8'h3C, 0, 0, -1);
        rx_frame(8'h00, 0, 0, -1);
        rx_frame(8'hFF, 1, 0, -1);
        // framing error (R6) then line held low: no new frame (R12)
        rx_frame(8'h81, 0, 1, -1);
        drive(1'b0, 2 * bit_len());
        repeat (64) @(negedge clk);
        chk("R12 no frame while low", rx_seen, 5);
        drive(1'b1, bit_len());
        rx_frame(8'h5A, 0, 0, -1);
        chk("R12 resync", rx_seen, 6);
        // short low pulse (R7)
        drive(1'b0, 64);
        drive(1'b1, 2 * bit_len());
        chk("R7 glitch ignored", rx_seen, 6);
        // one corrupted mid-bit sample (R8)
        rx_frame(8'h96, 0, 0, 0);
        rx_frame(8'h69, 0, 0, 5);
        repeat (64) @(negedge clk);
        chk("R8 vote frames", rx_seen, 8);
        chk("R4 queue drained", rx_exp.size(), 0);

        // transmit: ready timing (R10) and back-to-back (R11)
        tx_starts.delete();
        tx_send(8'hC3);
        chk("R10 ready low after load", tx_ready, 0);
        ready_time("R10 ready at stop");
        tx_send(8'h5E);
        tx_send(8'h01);
        tx_drain();
        chk("R11 frame count", tx_starts.size(), 3);
        for (int i = 1; i < tx_starts.size(); i++) begin
            int dlt;
            dlt = tx_starts[i] - tx_starts[i - 1];
            chk("R11 no gap", (dlt >= 11 * 256 - 8 + 1) && (dlt <= 11 * 256), 1);
        end

        // slow rate (R3)
        rate_slow = 1'b1;
        repeat (40) @(negedge clk);
        tx_send(8'h6B);
        ready_time("R3 slow bit period");
        tx_drain();
        base = rx_seen;
        rx_frame(8'h47, 0, 0, -1);
        repeat (64) @(negedge clk);
        chk("R3 slow rx", rx_seen, base + 1);
        rate_slow = 1'b0;
        repeat (40) @(negedge clk);

        // inverted polarity (R9)
        @(posedge clk);
        #1;
        idle_low = 1'b1;
        rx_pin   = 1'b0;
        repeat (8) @(negedge clk);
        chk("R9 tx idles low", tx_pin, 0);
        tx_send(8'h2D);
        tx_drain();
        base = rx_seen;
        rx_frame(8'hD2, 0, 0, -1);
        repeat (64) @(negedge clk);
        chk("R9 inverted rx", rx_seen, base + 1);
        chk("R1 tx queue drained", tx_exp.size(), 0);

        done = 1;
        summary();
        $finish;
    end
endmodule